// File: doc/BRIEF.md
# Multi-Channel Compare Timer Bank

This block is a bank of up-counting timers reached through a plain register bus with separate read and write strobes, a byte address and 32-bit data. Each channel has four registers: a control word, a clock-select word, the running counter and a compare value. Each channel counts in one of three modes. In one-shot mode it stops itself at the compare value. In repeat mode it reloads to zero at the compare value and keeps running. In free-running mode it never raises a compare event and rolls over at the top of its range. Each compare event latches a per-channel pending flag. The flags are masked by a shared enable register and combined into a single interrupt line. Software clears the flags by writing ones to a shared acknowledge location.

Counting is driven by two tick strobes on the one system clock, a fast one and a slow one. Each channel picks one of the two strobes and can pass either every strobe or every second strobe. A clear request in the control word zeroes the counter and restarts the halving phase. Software would typically keep one channel free-running as a time base and use another in repeat or one-shot mode to raise periodic or single interrupts.

Top module: `tmr_bank`

## Requirements
- R1: Channel n (1..NUM_CH) places its control word at byte offset 0x10*n, clock select at +0x04, counter at +0x08 and compare at +0x0C. The shared interrupt enable is at 0x00. The acknowledge location is at 0x08, and a read there returns the pending flags. Read data appears on `bus_rdata` on the clock after `bus_rd` is sampled.
- R2: While control bit 0 (enable) is 1, the counter adds one on each qualified tick. The counter register can be read at any time and can be written. With enable at 0 the counter holds.
- R3: In mode 1 (control bits [5:4] = 1, repeat), when the incremented value equals the compare value, the channel sets its pending flag, loads the counter with zero and keeps counting.
- R4: In mode 0 (one-shot), when the incremented value equals the compare value, the channel sets its pending flag, the counter stays at the compare value and control bit 0 drops to 0 by itself.
- R5: In mode 3 (free-running), and in the unused mode 2, no compare event is raised and the counter rolls over from all ones to zero.
- R6: Writing control bit 1 as 1 zeroes the counter, so it reads zero after that write, and restarts the divide-by-two phase. Bit 1 always reads back as 0, and the other control fields take the written value.
- R7: Clock-select bit 4 picks the tick source, 0 for the fast strobe and 1 for the slow strobe. Strobes on the unselected source have no effect on the counter.
- R8: Clock-select bit 0 set to 1 passes only every second selected strobe, starting with the second strobe after a clear. Set to 0, it passes every strobe.
- R9: Pending flag n-1 belongs to channel n. Writing ones to offset 0x08 clears the matching flags, so 0x3F clears all six, and zero bits leave their flags alone. A compare event in the same cycle as its acknowledge wins.
- R10: `irq` is the OR over all channels of the pending flag ANDed with its enable bit in the register at 0x00. Pending flags are set whether or not the enable bit is 1.
- R11: Compare values at both ends of the supported range, 3 and 0xFFFFFFFF, produce their events exactly when the counter reaches them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| fast_tick | input | 1 | Fast time-base strobe |
| slow_tick | input | 1 | Slow time-base strobe |
| irq | output | 1 | Combined, masked interrupt request |

## Verification
A wrong counter, mode or phase state in a channel shows up at the ports one read later, as a counter value that differs from the count of qualified strobes, or as a pending bit at the wrong time in the 0x08 read. A lost self-disable in one-shot mode shows as a counter that keeps counting past the compare value, and as control bit 0 still set. Errors in masking or acknowledge reach `irq` in the cycle right after the register write, so the bench samples `irq` at the falling edge that ends each write.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  // Counting behaviour selected by control bits [5:4]
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_SPARE  = 2'd2,
    MODE_FREE   = 2'd3
  } tmr_mode_e;

  // Word select inside a 16-byte channel window (address bits [3:2])
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CLK  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CMP  = 2'd3
  } tmr_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_SRC_BIT   = 4;
  localparam int CLK_DIV_BIT   = 0;

  // Only one-shot and repeat produce compare events
  function automatic logic mode_compares(tmr_mode_e m);
    return (m == MODE_ONCE) || (m == MODE_REPEAT);
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic src_slow,
  input  logic div_two,
  input  logic restart,
  output logic tick_out
);

  logic sel_tick;
  logic phase_q;

  assign sel_tick = src_slow ? slow_tick : fast_tick;
  assign tick_out = sel_tick & (~div_two | phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= 1'b0;
    else if (sel_tick)     phase_q <= ~phase_q;
  end

  // R8: with halving on, two passed ticks never come back to back
  p_div2_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_two && tick_out) |=> !(div_two && tick_out));

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_clk,
  input  logic              wr_cnt,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] clk_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic              match_evt
);

  function automatic logic [DATA_W-1:0] step(logic [DATA_W-1:0] v);
    return v + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic              en_q;
  tmr_mode_e         mode_q;
  logic              src_q;
  logic              div_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cmp_q;
  logic              clr_req;
  logic              tick;
  logic [DATA_W-1:0] cnt_next;

  assign clr_req  = wr_ctrl & wdata[CTRL_CLR_BIT];
  assign cnt_next = step(cnt_q);

  tmr_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .src_slow  (src_q),
    .div_two   (div_q),
    .restart   (clr_req),
    .tick_out  (tick)
  );

  assign match_evt = en_q & tick & mode_compares(mode_q) & (cnt_next == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
    end else if (wr_ctrl) begin
      en_q   <= wdata[CTRL_EN_BIT];
      mode_q <= tmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
    end else if (match_evt && mode_q == MODE_ONCE) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (wr_clk) begin
        src_q <= wdata[CLK_SRC_BIT];
        div_q <= wdata[CLK_DIV_BIT];
      end
      if (wr_cmp) cmp_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (wr_cnt)                             cnt_q <= wdata;
    else if (clr_req)                            cnt_q <= '0;
    else if (match_evt && mode_q == MODE_REPEAT) cnt_q <= '0;
    else if (en_q && tick)                       cnt_q <= cnt_next;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_EN_BIT] = en_q;
    ctrl_rd[CTRL_MODE_LSB +: 2] = mode_q;
    clk_rd = '0;
    clk_rd[CLK_SRC_BIT] = src_q;
    clk_rd[CLK_DIV_BIT] = div_q;
  end

  assign cnt_rd = cnt_q;
  assign cmp_rd = cmp_q;

  // R2: a stopped channel with no bus access keeps its count
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt && !clr_req) |=> $stable(cnt_q));

  // R3: repeat mode restarts from zero after a compare event
  p_repeat_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q == MODE_REPEAT && !wr_cnt && !clr_req) |=> (cnt_q == '0));

  // R4: one-shot mode disarms itself after its event
  p_once_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q == MODE_ONCE && !wr_ctrl) |=> !en_q);

  // R5: free-running counter rolls over to zero
  p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && mode_q == MODE_FREE && cnt_q == '1 && !wr_cnt && !clr_req)
      |=> (cnt_q == '0));

  // R6: a clear request zeroes the counter on the next cycle
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wr_cnt) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic              irq
);

  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  tmr_sel_e         sel;
  logic             aligned;

  assign blk     = bus_addr[ADDR_W-1:4];
  assign sel     = tmr_sel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] clk_rd  [NUM_CH];
  logic [DATA_W-1:0] cnt_rd  [NUM_CH];
  logic [DATA_W-1:0] cmp_rd  [NUM_CH];
  logic [NUM_CH-1:0] evt_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = bus_wr & aligned & (blk == BLK_W'(g + 1));

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (hit && sel == SEL_CTRL),
      .wr_clk    (hit && sel == SEL_CLK),
      .wr_cnt    (hit && sel == SEL_CNT),
      .wr_cmp    (hit && sel == SEL_CMP),
      .wdata     (bus_wdata),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .ctrl_rd   (ctrl_rd[g]),
      .clk_rd    (clk_rd[g]),
      .cnt_rd    (cnt_rd[g]),
      .cmp_rd    (cmp_rd[g]),
      .match_evt (evt_vec[g])
    );
  end

  // Shared interrupt registers in the window at block 0
  logic              shared_hit;
  logic              en_wr;
  logic [NUM_CH-1:0] ack_mask;
  logic [NUM_CH-1:0] irq_en_q;
  logic [NUM_CH-1:0] pend_q;

  assign shared_hit = bus_wr & aligned & (blk == '0);
  assign en_wr      = shared_hit && sel == SEL_CTRL;
  assign ack_mask   = (shared_hit && sel == SEL_CNT) ? bus_wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      pend_q   <= '0;
    end else begin
      if (en_wr) irq_en_q <= bus_wdata[NUM_CH-1:0];
      pend_q <= (pend_q & ~ack_mask) | evt_vec;
    end
  end

  assign irq = |(pend_q & irq_en_q);

  // Read path
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (aligned && blk == '0) begin
      if (sel == SEL_CTRL) rd_val[NUM_CH-1:0] = irq_en_q;
      if (sel == SEL_CNT)  rd_val[NUM_CH-1:0] = pend_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && blk == BLK_W'(i + 1)) begin
        case (sel)
          SEL_CTRL: rd_val = ctrl_rd[i];
          SEL_CLK:  rd_val = clk_rd[i];
          SEL_CNT:  rd_val = cnt_rd[i];
          default:  rd_val = cmp_rd[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R9: every compare event is visible in the pending flags next cycle
  p_pend_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

  // R9: acknowledged flags with no simultaneous event are gone next cycle
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_mask) |=> ((pend_q & $past(ack_mask) & ~$past(evt_vec)) == '0));

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  tmr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [1:0]  mode;
    logic        src;
    logic        div;
    logic        tsrc;
    logic [31:0] cmp;
    logic [7:0]  ticks;
    logic [31:0] exp_cnt;
    logic        exp_pend;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'd5,  8'd3,  32'd3, 1'b0},
    '{3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'd5,  8'd5,  32'd0, 1'b1},
    '{3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 32'd4,  8'd10, 32'd2, 1'b1},
    '{3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 32'd3,  8'd7,  32'd3, 1'b1},
    '{3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 32'd2,  8'd6,  32'd6, 1'b0},
    '{3'd6, 2'd1, 1'b1, 1'b0, 1'b1, 32'd3,  8'd2,  32'd2, 1'b0},
    '{3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 32'd10, 8'd7,  32'd3, 1'b0},
    '{3'd2, 2'd0, 1'b1, 1'b1, 1'b1, 32'd3,  8'd8,  32'd3, 1'b1},
    '{3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 32'd5,  8'd5,  32'd0, 1'b0}
  };
  localparam string TAGS [NV] = '{"R2", "R3", "R3", "R4", "R5", "R7", "R8", "R8", "R7"};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic slow, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] base(input int ch);
    return 8'(ch * 16);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #4000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    rd(8'h08, d); check("R9 pending after reset", d, 32'd0);
    rd(8'h10, d); check("R1 ctrl after reset", d, 32'd0);
    rd(8'h18, d); check("R2 count after reset", d, 32'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      int c;
      c = int'(VECS[v].ch);
      wr(base(c) + 8'h0, 32'h2);
      wr(base(c) + 8'h4, {27'd0, VECS[v].src, 3'd0, VECS[v].div});
      wr(base(c) + 8'hC, VECS[v].cmp);
      wr(8'h08, 32'h3F);
      wr(base(c) + 8'h0, {26'd0, VECS[v].mode, 4'h1});
      pulse(VECS[v].tsrc, int'(VECS[v].ticks));
      rd(base(c) + 8'h8, d);
      check(TAGS[v], d, VECS[v].exp_cnt);
      rd(8'h08, d);
      check(TAGS[v], {31'd0, d[c-1]}, {31'd0, VECS[v].exp_pend});
    end

    // R1/R6: register readback, clear bit reads 0
    wr(8'h3C, 32'hA5A5_0003); rd(8'h3C, d); check("R1 compare readback", d, 32'hA5A5_0003);
    wr(8'h34, 32'h11);        rd(8'h34, d); check("R1 clksel readback", d, 32'h11);
    wr(8'h30, 32'h33);        rd(8'h30, d); check("R6 clear bit reads 0", d, 32'h31);

    // R4: one-shot channel 4 disarmed itself
    rd(8'h40, d); check("R4 enable self-cleared", d, 32'h0);

    // R6: clear while running
    wr(8'h50, 32'h33); rd(8'h58, d); check("R6 counter zeroed", d, 32'd0);
    pulse(1'b0, 1);    rd(8'h58, d); check("R6 keeps counting after clear", d, 32'd1);

    // R11: top compare value
    wr(8'h10, 32'h2); wr(8'h14, 32'h0);
    wr(8'h18, 32'hFFFF_FFFC); wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h3F); wr(8'h10, 32'h11);
    pulse(1'b0, 3);
    rd(8'h18, d); check("R11 max compare reload", d, 32'd0);
    rd(8'h08, d); check("R11 max compare pending", {31'd0, d[0]}, 32'd1);

    // R5: free-running wrap, compare 0 ignored
    wr(8'h50, 32'h32); wr(8'h58, 32'hFFFF_FFFE); wr(8'h5C, 32'h0);
    wr(8'h08, 32'h3F); wr(8'h50, 32'h31);
    pulse(1'b0, 3);
    rd(8'h58, d); check("R5 wrap value", d, 32'd1);
    rd(8'h08, d); check("R5 no event", {31'd0, d[4]}, 32'd0);

    // R10: masking of the interrupt line
    wr(8'h10, 32'h2); wr(8'h14, 32'h0); wr(8'h1C, 32'd3);
    wr(8'h08, 32'h3F); wr(8'h00, 32'h02); wr(8'h10, 32'h11);
    pulse(1'b0, 3);
    rd(8'h08, d); check("R10 pending set while masked", {31'd0, d[0]}, 32'd1);
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h03);
    check("R10 irq raised", {31'd0, irq}, 32'd1);
    rd(8'h00, d); check("R1 enable readback", d, 32'h03);
    wr(8'h08, 32'h01);
    check("R9 irq dropped after ack", {31'd0, irq}, 32'd0);

    // R9: selective and full acknowledge
    pulse(1'b0, 3);
    pulse(1'b1, 3);
    rd(8'h08, d); check("R9 two flags pending", d & 32'h21, 32'h21);
    wr(8'h08, 32'h20);
    rd(8'h08, d); check("R9 zero bits leave flags", d & 32'h21, 32'h01);
    wr(8'h08, 32'h3F);
    rd(8'h08, d); check("R9 all flags cleared", d, 32'h0);

    finish_run();
  end

endmodule